// File: doc/BRIEF.md
# Snooping Cache Line Coherence Controller

This block keeps the four-state coherence status (Invalid, Shared, Exclusive, Modified) for every line of a small direct-mapped cache that sits on a shared snooping bus. Tag comparison happens outside the block. For each local processor access it receives the line index and a tag-match flag. It then decides whether the access completes at once, or which bus transaction it needs first: read, read-for-ownership, address-only invalidate, or write-back of a dirty victim.

The same block watches transactions that other caches place on the bus. For a snooped access that matches a local copy, it returns a shared indication or a retry. When the local copy is Modified, the block asserts retry and queues a write-back of that line ahead of any processor traffic. The other cache repeats its access once memory holds the data.

The processor request and the bus request are valid/ready streams. The processor holds `cpu_valid` and its fields stable until it sees `cpu_ready`, which is a one-cycle completion pulse. A bus request stays asserted and unchanged while `bus_req_ready` is low, unless a snoop arrives in between. The snoop pins are plain control: a snoop lasts one cycle, and the responses are combinational in that cycle.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid, no bus request is raised, and a snoop of any line gets neither retry nor shared.
- R2: A read whose line is not valid with a tag match issues bus op READ (code 0). It completes at the handshake and leaves the line Shared if `bus_shared_in` was high in that cycle, otherwise Exclusive.
- R3: A write that hits an Exclusive line completes in the same cycle with no bus request, and the line becomes Modified.
- R4: A write that hits a Shared line issues bus op INVALIDATE (code 2), completes at its handshake, and leaves the line Modified.
- R5: A write miss issues bus op READ-FOR-OWNERSHIP (code 1), completes at its handshake, and leaves the line Modified.
- R6: A snooped read that hits a local Exclusive or Shared copy asserts `snp_shared` in that cycle, and the line becomes Shared. Retry and shared are never asserted together.
- R7: A snooped write that hits a local Exclusive or Shared copy makes it Invalid, with neither response asserted.
- R8: A snoop that hits a Modified line asserts `snp_retry`. From the next cycle without a snoop, a WRITE-BACK (code 3) of that index is requested ahead of processor traffic. After it, the line is Shared for a snooped read or Invalid if any snooped write hit it.
- R9: A miss whose line holds a Modified copy of another tag first issues WRITE-BACK (code 3) without completing. It then issues the READ or READ-FOR-OWNERSHIP and completes on that one.
- R10: In a cycle with `snp_valid` high no bus request is raised. A processor access to the index that a matching snoop targets does not complete in that cycle, and the snoop's state change takes effect first.
- R11: While `bus_req_ready` is low, the bus request keeps its op and index, and the processor access does not complete.
- R12: A snoop with `snp_hit` low produces no response and leaves the line state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | Processor access present |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_idx | input | IDXW | Line index of the access |
| cpu_hit | input | 1 | Tag of the indexed line matches |
| cpu_ready | output | 1 | Access completes this cycle |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_ready | input | 1 | Bus accepts and completes the transaction |
| bus_req_op | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate, 3 write-back |
| bus_req_idx | output | IDXW | Line index of the transaction |
| bus_shared_in | input | 1 | Another cache holds the line (sampled at a read handshake) |
| snp_valid | input | 1 | Foreign bus transaction visible this cycle |
| snp_write | input | 1 | Foreign transaction seeks ownership or invalidates |
| snp_idx | input | IDXW | Line index of the foreign transaction |
| snp_hit | input | 1 | Tag of the indexed line matches the foreign address |
| snp_retry | output | 1 | Foreign requester must retry |
| snp_shared | output | 1 | This cache keeps a copy |

## Verification
The collision that matters is a local write hit to an Exclusive line landing in the same cycle as a snooped read of that same index. Either path alone would move the line, one to Modified and the other to Shared. The bench drives both in one cycle. It expects no completion and a shared response in that cycle, then an invalidate request on the following cycle, which shows that the snoop won and the write was carried out against the Shared line. A second overlap, a snoop arriving while a bus request waits for ready, is judged by the request dropping for that cycle and then returning unchanged.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_RFO  = 2'd1,
    OP_INV  = 2'd2,
    OP_WB   = 2'd3
  } bus_op_t;
endpackage

// File: rtl/mesi_state_array.sv
module mesi_state_array
  import mesi_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int IDXW   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] rd_a_idx,
  output line_st_t        rd_a_st,
  input  logic [IDXW-1:0] rd_b_idx,
  output line_st_t        rd_b_st,
  input  logic            snp_we,
  input  logic [IDXW-1:0] snp_widx,
  input  line_st_t        snp_wst,
  input  logic            bus_we,
  input  logic [IDXW-1:0] bus_widx,
  input  line_st_t        bus_wst,
  input  logic            cpu_we,
  input  logic [IDXW-1:0] cpu_widx,
  input  line_st_t        cpu_wst
);
  line_st_t line_q [NLINES];

  // Per-line update, snoop first, then bus completion, then silent upgrade
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLINES; i++) line_q[i] <= ST_I;
    end else begin
      for (int i = 0; i < NLINES; i++) begin
        if (snp_we && snp_widx == IDXW'(i))      line_q[i] <= snp_wst;
        else if (bus_we && bus_widx == IDXW'(i)) line_q[i] <= bus_wst;
        else if (cpu_we && cpu_widx == IDXW'(i)) line_q[i] <= cpu_wst;
      end
    end
  end

  assign rd_a_st = line_q[rd_a_idx];
  assign rd_b_st = line_q[rd_b_idx];
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
  import mesi_pkg::*;
#(
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            snp_valid,
  input  logic            snp_write,
  input  logic            snp_hit,
  input  logic [IDXW-1:0] snp_idx,
  input  line_st_t        snp_st,
  input  logic            wb_done,
  output logic            snp_retry,
  output logic            snp_shared,
  output logic            st_we,
  output line_st_t        st_wdata,
  output logic            wb_pend,
  output logic [IDXW-1:0] wb_idx,
  output logic            wb_to_inv
);
  logic match;

  always_comb begin
    match      = snp_valid && snp_hit && (snp_st != ST_I);
    snp_retry  = match && (snp_st == ST_M);
    snp_shared = match && !snp_write && (snp_st != ST_M);
    st_we      = match && (snp_st != ST_M);
    st_wdata   = snp_write ? ST_I : ST_S;
  end

  // One write-back slot; a dirty hit on another line is retried until free
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_pend   <= 1'b0;
      wb_idx    <= '0;
      wb_to_inv <= 1'b0;
    end else if (wb_done) begin
      wb_pend   <= 1'b0;
    end else if (snp_retry && !wb_pend) begin
      wb_pend   <= 1'b1;
      wb_idx    <= snp_idx;
      wb_to_inv <= snp_write;
    end else if (snp_retry && snp_idx == wb_idx) begin
      wb_to_inv <= wb_to_inv | snp_write;
    end
  end
endmodule

// File: rtl/mesi_bus_ctl.sv
module mesi_bus_ctl
  import mesi_pkg::*;
#(
  parameter int IDXW = 3
) (
  input  logic            cpu_valid,
  input  logic            cpu_write,
  input  logic            cpu_hit,
  input  logic [IDXW-1:0] cpu_idx,
  input  line_st_t        cpu_st,
  output logic            cpu_ready,
  input  logic            snp_valid,
  input  logic            snp_hit,
  input  logic [IDXW-1:0] snp_idx,
  input  logic            wb_pend,
  input  logic [IDXW-1:0] wb_idx,
  input  logic            wb_to_inv,
  output logic            wb_done,
  output logic            req_valid,
  input  logic            req_ready,
  output bus_op_t         req_op,
  output logic [IDXW-1:0] req_idx,
  input  logic            shared_in,
  output logic            bus_we,
  output line_st_t        bus_wst,
  output logic            cpu_we,
  output line_st_t        cpu_wst
);
  logic    stall, line_ok, need, local_done, hs;
  bus_op_t cpu_op;

  always_comb begin
    stall   = snp_valid && snp_hit && (snp_idx == cpu_idx);
    line_ok = cpu_hit && (cpu_st != ST_I);
    need    = 1'b0;
    cpu_op  = OP_READ;
    if (line_ok) begin
      if (cpu_write && cpu_st == ST_S) begin
        need   = 1'b1;
        cpu_op = OP_INV;
      end
    end else begin
      need = 1'b1;
      if (cpu_st == ST_M)  cpu_op = OP_WB;
      else if (cpu_write)  cpu_op = OP_RFO;
      else                 cpu_op = OP_READ;
    end

    local_done = cpu_valid && !stall && line_ok && !need;
    req_valid  = !snp_valid && (wb_pend || (cpu_valid && need));
    req_op     = wb_pend ? OP_WB : cpu_op;
    req_idx    = wb_pend ? wb_idx : cpu_idx;
    hs         = req_valid && req_ready;
    wb_done    = hs && wb_pend;
    cpu_ready  = local_done || (hs && !wb_pend && cpu_op != OP_WB);

    bus_we = hs;
    if (wb_pend) bus_wst = wb_to_inv ? ST_I : ST_S;
    else begin
      case (cpu_op)
        OP_READ: bus_wst = shared_in ? ST_S : ST_E;
        OP_RFO:  bus_wst = ST_M;
        OP_INV:  bus_wst = ST_M;
        default: bus_wst = ST_I;
      endcase
    end

    cpu_we  = local_done && cpu_write && (cpu_st == ST_E);
    cpu_wst = ST_M;
  end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int IDXW   = $clog2(NLINES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_valid,
  input  logic            cpu_write,
  input  logic [IDXW-1:0] cpu_idx,
  input  logic            cpu_hit,
  output logic            cpu_ready,
  output logic            bus_req_valid,
  input  logic            bus_req_ready,
  output logic [1:0]      bus_req_op,
  output logic [IDXW-1:0] bus_req_idx,
  input  logic            bus_shared_in,
  input  logic            snp_valid,
  input  logic            snp_write,
  input  logic [IDXW-1:0] snp_idx,
  input  logic            snp_hit,
  output logic            snp_retry,
  output logic            snp_shared
);
  line_st_t        cpu_st, snp_st, snp_wst, bus_wst, cpu_wst;
  logic            snp_we, bus_we, cpu_we;
  logic            wb_pend, wb_to_inv, wb_done;
  logic [IDXW-1:0] wb_idx;
  bus_op_t         op;

  mesi_state_array #(.NLINES(NLINES), .IDXW(IDXW)) u_array (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(cpu_idx), .rd_a_st(cpu_st),
    .rd_b_idx(snp_idx), .rd_b_st(snp_st),
    .snp_we(snp_we), .snp_widx(snp_idx), .snp_wst(snp_wst),
    .bus_we(bus_we), .bus_widx(bus_req_idx), .bus_wst(bus_wst),
    .cpu_we(cpu_we), .cpu_widx(cpu_idx), .cpu_wst(cpu_wst)
  );

  mesi_snoop_unit #(.IDXW(IDXW)) u_snoop (
    .clk(clk), .rst_n(rst_n),
    .snp_valid(snp_valid), .snp_write(snp_write), .snp_hit(snp_hit),
    .snp_idx(snp_idx), .snp_st(snp_st), .wb_done(wb_done),
    .snp_retry(snp_retry), .snp_shared(snp_shared),
    .st_we(snp_we), .st_wdata(snp_wst),
    .wb_pend(wb_pend), .wb_idx(wb_idx), .wb_to_inv(wb_to_inv)
  );

  mesi_bus_ctl #(.IDXW(IDXW)) u_bus (
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_hit(cpu_hit),
    .cpu_idx(cpu_idx), .cpu_st(cpu_st), .cpu_ready(cpu_ready),
    .snp_valid(snp_valid), .snp_hit(snp_hit), .snp_idx(snp_idx),
    .wb_pend(wb_pend), .wb_idx(wb_idx), .wb_to_inv(wb_to_inv),
    .wb_done(wb_done),
    .req_valid(bus_req_valid), .req_ready(bus_req_ready),
    .req_op(op), .req_idx(bus_req_idx), .shared_in(bus_shared_in),
    .bus_we(bus_we), .bus_wst(bus_wst),
    .cpu_we(cpu_we), .cpu_wst(cpu_wst)
  );

  assign bus_req_op = op;
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
  parameter int IDXW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cpu_valid,
  input logic [IDXW-1:0] cpu_idx,
  input logic            cpu_ready,
  input logic            bus_req_valid,
  input logic            bus_req_ready,
  input logic [1:0]      bus_req_op,
  input logic [IDXW-1:0] bus_req_idx,
  input logic            snp_valid,
  input logic [IDXW-1:0] snp_idx,
  input logic            snp_hit,
  input logic            snp_retry,
  input logic            snp_shared
);
  assert_bus_yield_R10: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !bus_req_valid);

  assert_cpu_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && snp_valid && snp_hit && snp_idx == cpu_idx) |-> !cpu_ready);

  assert_wb_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    snp_retry |=> (snp_valid || (bus_req_valid && bus_req_op == 2'd3)));

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_valid && !bus_req_ready) |=>
      (snp_valid || !cpu_valid ||
       (bus_req_valid && $stable(bus_req_op) && $stable(bus_req_idx))));

  assert_resp_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    snp_retry |-> !snp_shared);

  assert_no_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!snp_valid || !snp_hit) |-> (!snp_retry && !snp_shared));
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_idx(cpu_idx),
  .cpu_ready(cpu_ready), .bus_req_valid(bus_req_valid),
  .bus_req_ready(bus_req_ready), .bus_req_op(bus_req_op),
  .bus_req_idx(bus_req_idx), .snp_valid(snp_valid), .snp_idx(snp_idx),
  .snp_hit(snp_hit), .snp_retry(snp_retry), .snp_shared(snp_shared)
);

// File: tb/sim_mesi_line_ctrl.sv
module sim_mesi_line_ctrl;
  localparam int IDXW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_valid = 0, cpu_write = 0, cpu_hit = 0, cpu_ready;
  logic [IDXW-1:0] cpu_idx = '0;
  logic bus_req_valid, bus_req_ready = 1'b1, bus_shared_in = 1'b0;
  logic [1:0] bus_req_op;
  logic [IDXW-1:0] bus_req_idx;
  logic snp_valid = 0, snp_write = 0, snp_hit = 0, snp_retry, snp_shared;
  logic [IDXW-1:0] snp_idx = '0;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mesi_line_ctrl #(.NLINES(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
    .cpu_idx(cpu_idx), .cpu_hit(cpu_hit), .cpu_ready(cpu_ready),
    .bus_req_valid(bus_req_valid), .bus_req_ready(bus_req_ready),
    .bus_req_op(bus_req_op), .bus_req_idx(bus_req_idx),
    .bus_shared_in(bus_shared_in), .snp_valid(snp_valid),
    .snp_write(snp_write), .snp_idx(snp_idx), .snp_hit(snp_hit),
    .snp_retry(snp_retry), .snp_shared(snp_shared)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Processor access; bench acts as bus with current ready/shared settings
  task automatic cpu_run(input logic w, input int idx, input logic hit, input logic shr,
                         output int nb, output int op0, output int op1, output int cyc);
    @(negedge clk);
    cpu_valid = 1; cpu_write = w; cpu_idx = IDXW'(idx); cpu_hit = hit;
    bus_shared_in = shr;
    nb = 0; op0 = -1; op1 = -1; cyc = 0;
    for (int c = 0; c < 16; c++) begin
      #1;
      if (bus_req_valid && bus_req_ready) begin
        if (nb == 0) op0 = int'(bus_req_op); else op1 = int'(bus_req_op);
        nb++;
      end
      if (cpu_ready) break;
      cyc++;
      @(negedge clk);
    end
    @(negedge clk);
    cpu_valid = 0;
  endtask

  task automatic snoop(input logic w, input int idx, input logic hit,
                       output int r, output int s);
    @(negedge clk);
    snp_valid = 1; snp_write = w; snp_idx = IDXW'(idx); snp_hit = hit;
    #1;
    r = int'(snp_retry); s = int'(snp_shared);
    @(negedge clk);
    snp_valid = 0;
  endtask

  task automatic expect_wb(input string req, input int idx);
    #1;
    chk(req, "write-back valid", int'(bus_req_valid), 1);
    chk(req, "write-back op", int'(bus_req_op), 3);
    chk(req, "write-back idx", int'(bus_req_idx), idx);
    @(negedge clk);
  endtask

  task automatic t_reset;
    int r, s;
    #1;
    chk("R1", "no bus request", int'(bus_req_valid), 0);
    chk("R1", "no completion", int'(cpu_ready), 0);
    snoop(1'b0, 0, 1'b1, r, s);
    chk("R1", "retry on invalid", r, 0);
    chk("R1", "shared on invalid", s, 0);
  endtask

  task automatic t_read_exclusive;
    int nb, o0, o1, cy, r, s;
    cpu_run(1'b0, 1, 1'b0, 1'b0, nb, o0, o1, cy);
    chk("R2", "read miss op", o0, 0);
    chk("R2", "read miss bus count", nb, 1);
    cpu_run(1'b1, 1, 1'b1, 1'b0, nb, o0, o1, cy);
    chk("R3", "write hit E bus count", nb, 0);
    chk("R3", "write hit E latency", cy, 0);
    snoop(1'b0, 1, 1'b1, r, s);
    chk("R3", "line modified gives retry", r, 1);
    chk("R8", "no shared with retry", s, 0);
    expect_wb("R8", 1);
    snoop(1'b0, 1, 1'b1, r, s);
    chk("R8", "after wb read-snoop line shared", s, 1);
    chk("R8", "after wb no retry", r, 0);
  endtask

  task automatic t_read_shared;
    int nb, o0, o1, cy, r, s;
    cpu_run(1'b0, 2, 1'b0, 1'b1, nb, o0, o1, cy);
    chk("R2", "read miss op shared", o0, 0);
    cpu_run(1'b1, 2, 1'b1, 1'b0, nb, o0, o1, cy);
    chk("R4", "write hit S op", o0, 2);
    chk("R4", "write hit S bus count", nb, 1);
    snoop(1'b1, 2, 1'b1, r, s);
    chk("R4", "after invalidate line modified", r, 1);
    expect_wb("R8", 2);
    snoop(1'b0, 2, 1'b1, r, s);
    chk("R8", "after wb write-snoop invalid shared", s, 0);
    chk("R8", "after wb write-snoop invalid retry", r, 0);
  endtask

  task automatic t_write_miss;
    int nb, o0, o1, cy, r, s;
    cpu_run(1'b1, 3, 1'b0, 1'b0, nb, o0, o1, cy);
    chk("R5", "write miss op", o0, 1);
    chk("R5", "write miss bus count", nb, 1);
    snoop(1'b1, 3, 1'b0, r, s);
    chk("R12", "tag mismatch retry", r, 0);
    chk("R12", "tag mismatch shared", s, 0);
    cpu_run(1'b1, 3, 1'b1, 1'b0, nb, o0, o1, cy);
    chk("R12", "line still modified, no bus", nb, 0);
    snoop(1'b0, 3, 1'b1, r, s);
    chk("R5", "write miss left line modified", r, 1);
    expect_wb("R8", 3);
  endtask

  task automatic t_snoop_exclusive;
    int nb, o0, o1, cy, r, s;
    cpu_run(1'b0, 4, 1'b0, 1'b0, nb, o0, o1, cy);
    snoop(1'b0, 4, 1'b1, r, s);
    chk("R6", "read snoop on E shared", s, 1);
    chk("R6", "read snoop on E retry", r, 0);
    cpu_run(1'b1, 4, 1'b1, 1'b0, nb, o0, o1, cy);
    chk("R6", "E became S so invalidate", o0, 2);
  endtask

  task automatic t_snoop_invalidate;
    int nb, o0, o1, cy, r, s;
    cpu_run(1'b0, 5, 1'b0, 1'b1, nb, o0, o1, cy);
    snoop(1'b1, 5, 1'b1, r, s);
    chk("R7", "write snoop on S retry", r, 0);
    chk("R7", "write snoop on S shared", s, 0);
    cpu_run(1'b0, 5, 1'b1, 1'b0, nb, o0, o1, cy);
    chk("R7", "line invalid so read reissued", o0, 0);
    chk("R7", "one bus op", nb, 1);
  endtask

  task automatic t_victim;
    int nb, o0, o1, cy;
    cpu_run(1'b1, 6, 1'b0, 1'b0, nb, o0, o1, cy);
    cpu_run(1'b0, 6, 1'b0, 1'b0, nb, o0, o1, cy);
    chk("R9", "victim bus count", nb, 2);
    chk("R9", "victim first op", o0, 3);
    chk("R9", "victim second op", o1, 0);
  endtask

  task automatic t_collide;
    int nb, o0, o1, cy;
    cpu_run(1'b0, 7, 1'b0, 1'b0, nb, o0, o1, cy);
    @(negedge clk);
    cpu_valid = 1; cpu_write = 1; cpu_idx = 3'd7; cpu_hit = 1;
    snp_valid = 1; snp_write = 0; snp_idx = 3'd7; snp_hit = 1;
    #1;
    chk("R10", "write stalled under snoop", int'(cpu_ready), 0);
    chk("R10", "no bus request under snoop", int'(bus_req_valid), 0);
    chk("R6", "snoop shared on E", int'(snp_shared), 1);
    @(negedge clk);
    snp_valid = 0;
    #1;
    chk("R10", "write now invalidates", int'(bus_req_op), 2);
    chk("R10", "invalidate valid", int'(bus_req_valid), 1);
    chk("R4", "completes at handshake", int'(cpu_ready), 1);
    @(negedge clk);
    cpu_valid = 0;
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    bus_req_ready = 0;
    cpu_valid = 1; cpu_write = 0; cpu_idx = 3'd0; cpu_hit = 0;
    #1;
    chk("R11", "request raised", int'(bus_req_valid), 1);
    chk("R11", "no completion without ready", int'(cpu_ready), 0);
    @(negedge clk);
    #1;
    chk("R11", "op held", int'(bus_req_op), 0);
    chk("R11", "idx held", int'(bus_req_idx), 0);
    @(negedge clk);
    snp_valid = 1; snp_write = 0; snp_idx = 3'd3; snp_hit = 0;
    #1;
    chk("R10", "request dropped during snoop", int'(bus_req_valid), 0);
    @(negedge clk);
    snp_valid = 0; bus_req_ready = 1; bus_shared_in = 0;
    #1;
    chk("R11", "request back", int'(bus_req_valid), 1);
    chk("R11", "completes with ready", int'(cpu_ready), 1);
    @(negedge clk);
    cpu_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_read_exclusive();
    t_read_shared();
    t_write_miss();
    t_snoop_exclusive();
    t_snoop_invalidate();
    t_victim();
    t_collide();
    t_backpressure();
    repeat (2) @(negedge clk);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule